// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single 16-bit down-counting channel of a legacy interval timer. It advances only on cycles where the count-clock enable `cnt_en` is high. An initial count, a mode code and a decimal-counting flag are loaded together through a valid/ready port. The channel then produces a live count value and an output waveform whose shape depends on the mode. There are six modes: interrupt on terminal count, gate-triggered one-shot, rate generator, square wave, and two single-tick strobes, one started by software and one by the gate.

The load port is always ready, so `load_ready` is tied high and back-pressure never occurs. A load transfers on every cycle where `load_valid` is high. The loaded count does not appear straight away. It is copied into the counter on the first `cnt_en` cycle after the transfer, and counting starts from that point. The gate input is sampled on `clk`. In the level-gated modes it allows or holds counting. In the other modes its rising edge restarts the period.

Top module: `pit_channel`

## Requirements
- R1: After reset `count_out` is 0, `out` is 0 and `load_ready` is 1. `out` stays 0 whatever `gate` and `cnt_en` do until the first load.
- R2: A load is captured in the cycle `load_valid` is high. The new count appears on `count_out` at the first `cnt_en` cycle after that, and this reload tick is not a counting step. A `cnt_en` in the load cycle itself has no effect.
- R3: Mode codes 6 and 7 behave exactly as modes 2 and 3.
- R4: A loaded count of 0 means a period of 65536 steps in binary, or 10000 steps when `load_bcd` is 1.
- R5: In modes 0, 1, 4 and 5 the counter passes through zero and continues from FFFF hex in binary, or from 9999 in BCD, where each nibble is one decimal digit with the least significant digit in bits 3:0.
- R6: In modes 0 and 4 a step happens only on `cnt_en` cycles with `gate` high. In modes 1, 2, 3 and 5 the gate level is ignored. A rising edge of `gate` (low in one `clk` cycle, high in the next) arms a restart from the initial count at the next `cnt_en`. Edges before the first load, or in a load cycle, are ignored.
- R7: Mode 0: `out` is low from the load and goes high after N steps. It then stays high, through wraps, until the next load.
- R8: Mode 1: `out` is high from the load and through the first N-1 steps. It goes low at step N and stays low until a load or a restart.
- R9: Mode 2: at every N-th step the counter reloads N instead of reaching 0, and `out` is high from that step to the next step. `out` is never high at the reload tick.
- R10: Mode 3: `out` is high for the first ceil(N/2) steps of each period and low for the remaining floor(N/2) steps. Within each half the count restarts at N and falls by 2 per step. With N=1, `out` stays high.
- R11: Modes 4 and 5: `out` is high only between step N and step N+1 after a reload, once per reload.
- R12: `count_out` changes only in cycles with `cnt_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Count-clock enable, one step or reload per high cycle |
| load_valid | input | 1 | Load request for count, mode and BCD flag |
| load_ready | output | 1 | Always 1, load accepted every cycle |
| load_count | input | 16 | Initial count, binary or four BCD digits |
| load_mode | input | 3 | Mode code 0..7 |
| load_bcd | input | 1 | 1 selects decimal counting |
| gate | input | 1 | Gate level / restart trigger |
| count_out | output | 16 | Live counter value |
| out | output | 1 | Channel output waveform |

## Verification
The assertions assume that every count loaded with `load_bcd` set uses only decimal digits 0 to 9. They also assume that all inputs are known and change only away from the rising clock edge. Under those assumptions, the mode-dependent properties (the sticky terminal flag, single-tick strobes, and a rate pulse that appears only with the reloaded value) follow from the register state. The stimulus drives inputs on the falling edge and loads only valid digit codes in BCD mode. It varies the spacing of `cnt_en` between dense, sparse and pseudo-random patterns, so each mode is seen both with long idle gaps and with back-to-back steps.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int CNT_W  = 16;
  localparam int DIGITS = CNT_W / 4;
  localparam int NB_W   = CNT_W + 1;

  typedef enum logic [2:0] {
    M_INT_TC    = 3'd0,
    M_ONESHOT   = 3'd1,
    M_RATE      = 3'd2,
    M_SQUARE    = 3'd3,
    M_SW_STROBE = 3'd4,
    M_HW_STROBE = 3'd5
  } mode_e;

  function automatic mode_e fold_mode(input logic [2:0] code);
    if (code > 3'd5) return mode_e'(code - 3'd4);
    return mode_e'(code);
  endfunction

  // one step down, binary or per-digit decimal with borrow
  function automatic logic [CNT_W-1:0] dec_one(input logic [CNT_W-1:0] v, input logic bcd);
    logic [CNT_W-1:0] r;
    logic borrow;
    if (!bcd) return v - 1'b1;
    r = v;
    borrow = 1'b1;
    for (int i = 0; i < DIGITS; i++) begin
      if (borrow) begin
        if (v[4*i +: 4] == 4'd0) r[4*i +: 4] = 4'd9;
        else begin
          r[4*i +: 4] = v[4*i +: 4] - 4'd1;
          borrow = 1'b0;
        end
      end
    end
    return r;
  endfunction

  function automatic logic [NB_W-1:0] bcd_to_bin(input logic [CNT_W-1:0] v);
    int acc;
    acc = 0;
    for (int i = DIGITS - 1; i >= 0; i--) acc = acc * 10 + int'(v[4*i +: 4]);
    return NB_W'(acc);
  endfunction

  function automatic logic [NB_W-1:0] full_span(input logic bcd);
    int p;
    p = 1;
    for (int i = 0; i < DIGITS; i++) p = p * 10;
    if (bcd) return NB_W'(p);
    return NB_W'(1) << CNT_W;
  endfunction
endpackage

// File: rtl/pit_gate_ctrl.sv
module pit_gate_ctrl
  import pit_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  gate,
  input  logic  loaded,
  input  logic  load_fire,
  input  mode_e mode_q,
  output logic  step_ok,
  output logic  retrig
);
  logic gate_q;
  logic level_gated;

  always_ff @(posedge clk) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate;
  end

  assign level_gated = (mode_q == M_INT_TC) || (mode_q == M_SW_STROBE);
  assign step_ok     = gate || !level_gated;
  assign retrig      = loaded && !load_fire && gate && !gate_q && !level_gated;

  // R6: a restart request never comes from a level-gated mode
  assert_retrig_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    retrig |-> (mode_q != M_INT_TC && mode_q != M_SW_STROBE));
endmodule

// File: rtl/pit_count_core.sv
module pit_count_core
  import pit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             load_fire,
  input  logic [CNT_W-1:0] load_count,
  input  mode_e            load_mode,
  input  logic             load_bcd,
  input  logic             step_ok,
  input  logic             retrig,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] init_q,
  output mode_e            mode_q,
  output logic             loaded,
  output logic             tc_seen,
  output logic             pulse,
  output logic             phase_high
);
  logic            bcd_q;
  logic            pending;
  logic [NB_W-1:0] rem;
  logic [NB_W-1:0] n_bin;
  logic [NB_W-1:0] hi_len;
  logic [NB_W-1:0] lo_len;

  always_comb begin
    if (init_q == '0)  n_bin = full_span(bcd_q);
    else if (bcd_q)    n_bin = bcd_to_bin(init_q);
    else               n_bin = NB_W'(init_q);
    hi_len = (n_bin + 1'b1) >> 1;
    lo_len = n_bin >> 1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      init_q     <= '0;
      mode_q     <= M_INT_TC;
      bcd_q      <= 1'b0;
      loaded     <= 1'b0;
      pending    <= 1'b0;
      tc_seen    <= 1'b0;
      pulse      <= 1'b0;
      phase_high <= 1'b0;
      rem        <= '0;
    end else if (load_fire) begin
      init_q     <= load_count;
      mode_q     <= load_mode;
      bcd_q      <= load_bcd;
      loaded     <= 1'b1;
      pending    <= 1'b1;
      tc_seen    <= 1'b0;
      pulse      <= 1'b0;
      phase_high <= 1'b1;
    end else begin
      if (cnt_en) begin
        if (pending) begin
          cnt        <= init_q;
          tc_seen    <= 1'b0;
          pulse      <= 1'b0;
          phase_high <= 1'b1;
          rem        <= hi_len;
          pending    <= 1'b0;
        end else if (loaded && step_ok) begin
          case (mode_q)
            M_RATE: begin
              if (cnt == CNT_W'(1)) begin
                cnt   <= init_q;
                pulse <= 1'b1;
              end else begin
                cnt   <= dec_one(cnt, bcd_q);
                pulse <= 1'b0;
              end
            end
            M_SQUARE: begin
              if (rem == NB_W'(1)) begin
                cnt <= init_q;
                if (phase_high && lo_len != '0) begin
                  phase_high <= 1'b0;
                  rem        <= lo_len;
                end else begin
                  phase_high <= 1'b1;
                  rem        <= hi_len;
                end
              end else begin
                cnt <= dec_one(dec_one(cnt, bcd_q), bcd_q);
                rem <= rem - 1'b1;
              end
            end
            default: begin
              cnt <= dec_one(cnt, bcd_q);
              if (cnt == CNT_W'(1) && !tc_seen) begin
                tc_seen <= 1'b1;
                pulse   <= 1'b1;
              end else begin
                pulse   <= 1'b0;
              end
            end
          endcase
        end
      end
      if (retrig) pending <= 1'b1;
    end
  end

  assert_hold_no_enable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(cnt));

  assert_mode_folded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q inside {M_INT_TC, M_ONESHOT, M_RATE, M_SQUARE, M_SW_STROBE, M_HW_STROBE});

  assert_strobe_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_HW_STROBE && pulse && cnt_en && !load_fire) |=> !pulse);
endmodule

// File: rtl/pit_out_gen.sv
module pit_out_gen
  import pit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_fire,
  input  mode_e            mode_q,
  input  logic             loaded,
  input  logic             tc_seen,
  input  logic             pulse,
  input  logic             phase_high,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] init_q,
  output logic             out
);
  always_comb begin
    case (mode_q)
      M_INT_TC:    out = tc_seen;
      M_ONESHOT:   out = loaded && !tc_seen;
      M_SQUARE:    out = loaded && phase_high;
      M_RATE,
      M_SW_STROBE,
      M_HW_STROBE: out = pulse;
      default:     out = 1'b0;
    endcase
  end

  assert_idle_before_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !loaded |-> !out);

  assert_tc_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_INT_TC && out && !load_fire) |=> out);

  assert_rate_pulse_value_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RATE && out) |-> (cnt == init_q));
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             load_valid,
  output logic             load_ready,
  input  logic [CNT_W-1:0] load_count,
  input  logic [2:0]       load_mode,
  input  logic             load_bcd,
  input  logic             gate,
  output logic [CNT_W-1:0] count_out,
  output logic             out
);
  logic             load_fire;
  logic             step_ok;
  logic             retrig;
  logic [CNT_W-1:0] init_q;
  mode_e            mode_q;
  logic             loaded;
  logic             tc_seen;
  logic             pulse;
  logic             phase_high;

  assign load_ready = 1'b1;
  assign load_fire  = load_valid && load_ready;

  pit_gate_ctrl u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .gate      (gate),
    .loaded    (loaded),
    .load_fire (load_fire),
    .mode_q    (mode_q),
    .step_ok   (step_ok),
    .retrig    (retrig)
  );

  pit_count_core u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_en     (cnt_en),
    .load_fire  (load_fire),
    .load_count (load_count),
    .load_mode  (fold_mode(load_mode)),
    .load_bcd   (load_bcd),
    .step_ok    (step_ok),
    .retrig     (retrig),
    .cnt        (count_out),
    .init_q     (init_q),
    .mode_q     (mode_q),
    .loaded     (loaded),
    .tc_seen    (tc_seen),
    .pulse      (pulse),
    .phase_high (phase_high)
  );

  pit_out_gen u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_fire  (load_fire),
    .mode_q     (mode_q),
    .loaded     (loaded),
    .tc_seen    (tc_seen),
    .pulse      (pulse),
    .phase_high (phase_high),
    .cnt        (count_out),
    .init_q     (init_q),
    .out        (out)
  );
endmodule

// File: tb/tb_pit_channel.sv
module tb_pit_channel;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cnt_en;
  logic        load_valid;
  logic        load_ready;
  logic [15:0] load_count;
  logic [2:0]  load_mode;
  logic        load_bcd;
  logic        gate;
  logic [15:0] count_out;
  logic        out;

  pit_channel dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .load_valid(load_valid),
    .load_ready(load_ready), .load_count(load_count), .load_mode(load_mode),
    .load_bcd(load_bcd), .gate(gate), .count_out(count_out), .out(out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_checks = 0;
  int    n_fails  = 0;
  bit    started  = 0;
  bit    done     = 0;
  string cur_req  = "R1";
  logic [31:0] lcg = 32'h1234_5678;

  // behavioural reference, elapsed-step based
  int m_n, m_mode, m_bcd, m_loaded, m_pend, m_d, m_gprev, m_disp, m_span;

  function automatic int code_to_num(int code, int b);
    int v;
    if (code == 0) return b ? 10000 : 65536;
    if (!b) return code;
    v = ((code >> 12) & 15) * 1000 + ((code >> 8) & 15) * 100 + ((code >> 4) & 15) * 10 + (code & 15);
    return v;
  endfunction

  function automatic int num_to_code(int v, int b);
    if (!b) return v;
    return ((v / 1000) % 10) * 4096 + ((v / 100) % 10) * 256 + ((v / 10) % 10) * 16 + (v % 10);
  endfunction

  function automatic int model_disp();
    int v, pos, ce, k;
    case (m_mode)
      2: v = (m_n - (m_d % m_n)) % m_span;
      3: begin
        pos = m_d % m_n;
        ce  = (m_n + 1) / 2;
        k   = (pos < ce) ? pos : pos - ce;
        v   = ((m_n - 2 * k) % m_span + m_span) % m_span;
      end
      default: v = ((m_n - m_d) % m_span + m_span) % m_span;
    endcase
    return num_to_code(v, m_bcd);
  endfunction

  function automatic bit model_out();
    if (!m_loaded) return 1'b0;
    case (m_mode)
      0: return m_d >= m_n;
      1: return m_d < m_n;
      2: return (m_d > 0) && (m_d % m_n == 0);
      3: return (m_d % m_n) < ((m_n + 1) / 2);
      default: return m_d == m_n;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_n = 1; m_mode = 0; m_bcd = 0; m_loaded = 0; m_pend = 0;
      m_d = 0; m_gprev = 0; m_disp = 0; m_span = 65536;
    end else begin
      if (load_valid) begin
        m_mode   = (load_mode > 5) ? int'(load_mode) - 4 : int'(load_mode);
        m_bcd    = int'(load_bcd);
        m_span   = m_bcd ? 10000 : 65536;
        m_n      = code_to_num(int'(load_count), m_bcd);
        m_loaded = 1; m_pend = 1; m_d = 0;
      end else begin
        if (cnt_en) begin
          if (m_pend) begin
            m_pend = 0; m_d = 0; m_disp = model_disp();
          end else if (m_loaded && (gate || !(m_mode == 0 || m_mode == 4))) begin
            m_d = m_d + 1; m_disp = model_disp();
          end
        end
        if (gate && !m_gprev && m_loaded && m_mode != 0 && m_mode != 4) m_pend = 1;
      end
      m_gprev = int'(gate);
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (started && rst_n && !done) begin
      n_checks++;
      if (int'(count_out) != m_disp) begin
        n_fails++;
        $display("FAIL %s count_out act=%h exp=%h t=%0t", cur_req, count_out, m_disp[15:0], $time);
      end
      n_checks++;
      if (out != model_out()) begin
        n_fails++;
        $display("FAIL %s out act=%b exp=%b t=%0t", cur_req, out, model_out(), $time);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  endtask

  task automatic run(int n, int pat);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      case (pat)
        0: cnt_en = 1'b1;
        1: cnt_en = (i % 3 == 0);
        default: begin
          lcg = lcg * 32'd1103515245 + 32'd12345;
          cnt_en = lcg[16];
        end
      endcase
    end
  endtask

  task automatic do_load(logic [15:0] v, logic [2:0] m, logic b);
    @(negedge clk);
    load_valid = 1'b1; load_count = v; load_mode = m; load_bcd = b;
    @(negedge clk);
    load_valid = 1'b0;
  endtask

  task automatic pulse_gate();
    @(negedge clk); gate = 1'b0;
    @(negedge clk); gate = 1'b1;
  endtask

  initial begin
    rst_n = 0; cnt_en = 0; load_valid = 0; load_count = 0;
    load_mode = 0; load_bcd = 0; gate = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state and ready
    n_checks++;
    if (count_out !== 16'h0 || out !== 1'b0 || load_ready !== 1'b1) begin
      n_fails++;
      $display("FAIL R1 reset act=%h/%b/%b exp=0000/0/1", count_out, out, load_ready);
    end
    started = 1;
    cur_req = "R1"; gate = 1; run(4, 0); gate = 0; run(3, 0); gate = 1; run(4, 2);

    // R2: load with enable in the same cycle, sparse enables
    cur_req = "R2"; cnt_en = 1; do_load(16'd5, 3'd0, 1'b0); run(20, 1);
    // R7: terminal flag, sticky
    cur_req = "R7"; do_load(16'd3, 3'd0, 1'b0); run(12, 0);
    // R6: level gating in modes 0 and 4
    cur_req = "R6"; do_load(16'd6, 3'd0, 1'b0); run(3, 0); gate = 0; run(5, 0); gate = 1; run(8, 2);
    do_load(16'd4, 3'd4, 1'b0); run(2, 0); gate = 0; run(4, 0); gate = 1; run(3, 0); gate = 0; run(3, 0); gate = 1; run(6, 0);
    // R8: one-shot with restart
    cur_req = "R8"; do_load(16'd4, 3'd1, 1'b0); run(3, 0); pulse_gate(); run(10, 0); pulse_gate(); run(8, 2);
    // R9: rate generator, several counts, restart
    cur_req = "R9"; do_load(16'd3, 3'd2, 1'b0); run(14, 0); pulse_gate(); run(10, 2);
    do_load(16'd1, 3'd2, 1'b0); run(6, 0);
    // R10: square wave odd, even, one, decimal
    cur_req = "R10"; do_load(16'd5, 3'd3, 1'b0); run(22, 0);
    do_load(16'd6, 3'd3, 1'b0); run(20, 2);
    do_load(16'd1, 3'd3, 1'b0); run(5, 0);
    do_load(16'h0007, 3'd3, 1'b1); run(20, 0); pulse_gate(); run(10, 0);
    // R11: strobes, software and gate-started
    cur_req = "R11"; do_load(16'd3, 3'd4, 1'b0); run(10, 0);
    do_load(16'd2, 3'd5, 1'b0); run(6, 0); pulse_gate(); run(8, 1);
    // R3: codes 6 and 7
    cur_req = "R3"; do_load(16'd4, 3'd6, 1'b0); run(14, 0);
    do_load(16'd3, 3'd7, 1'b0); run(12, 0);
    // R5: wrap in decimal and binary
    cur_req = "R5"; do_load(16'h0002, 3'd1, 1'b1); run(8, 0);
    do_load(16'd2, 3'd4, 1'b0); run(8, 0);
    do_load(16'h0010, 3'd5, 1'b1); run(16, 2);
    // R12: count holds across long enable gaps
    cur_req = "R12"; do_load(16'd9, 3'd2, 1'b0); run(30, 1);
    // R4: zero means full range
    cur_req = "R4"; do_load(16'h0000, 3'd0, 1'b0); run(65540, 0);
    do_load(16'h0000, 3'd2, 1'b1); run(20005, 0);
    run(2, 0);
    finish_run();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fails++;
    $display("FAIL %s watchdog expired act=running exp=finished", cur_req);
    finish_run();
  end
endmodule